// File: doc/BRIEF.md
# Latency-Aware Flash Write-Point Allocator

This block sits inside a flash translation layer and decides where each page write lands. It holds a single write point, a block index plus a page index, and hands out page addresses in strictly rising order inside the open block. When a block runs out of pages, the next write opens the oldest block waiting in an internal erased-block FIFO. If that FIFO is empty, the block stalls the request.

On multi-level-cell parts, some pages program far faster than others, in a fixed pattern by page index. A write that wants low latency can jump forward to the next fast page. The pages it passes over become invalid. The number of such pages is limited by a spare-page budget, and past that budget the write takes the next page as a slow write would. Host writes marked high priority want fast pages. Garbage-collection writes want fast pages only when a global fast mode is on. Fast mode is on, for example, on battery power or while urgent work is queued.

The allocator also watches the erased-pool level. It raises an urgent cleaning request and a background cleaning request, each with its own hysteresis band. Two counters report how many pages were skipped and how many blocks were opened.

Top module: `fwp_alloc`

## Requirements
- R1: Within one open block, each returned page index is strictly greater than the one returned before it. The write point never moves backwards.
- R2: A write is accepted on a clock edge where `req_valid` and `req_ready` are both high. On the next cycle, `resp_valid` is high for exactly one cycle and carries the block and page chosen for that write.
- R3: After page PAGES-1 of a block has been returned, the next accepted write pops the oldest entry of the erased pool, gets page 0 of that block, and increments `blocks_used` by one. The same happens for the first write after reset.
- R4: `req_ready` is low exactly when no block is open and the erased pool is empty. A request held during a stall is accepted once a block index is pushed.
- R5: With `pat_sel`=0, pages 0 to 3 are fast. From page 4 on, a page p is fast when p mod 4 is 2 or 3 and slow when p mod 4 is 0 or 1.
- R6: With `pat_sel`=1, even pages are fast and odd pages are slow.
- R7: A write wants a fast page when `fast_mode` is high, or when `req_hi`=1 and `req_gc`=0. Such a write takes the lowest fast page at or above the write point, if R9 allows it. Any other write takes the page at the write point.
- R8: A write with `req_gc`=1 takes the page at the write point whatever `req_hi` is, unless `fast_mode` is high.
- R9: A fast-seeking write skips gap = chosen page minus write point pages only if `skip_total` + gap is at most `skip_budget` and a fast page remains in the block. Otherwise it takes the page at the write point. `skip_total` grows by the gap actually skipped.
- R10: `gc_req` is registered from the pool count. It goes high the cycle after the count is below WM_LOW, goes low the cycle after the count is at least WM_MED, and holds its value in between.
- R11: `bg_clean` goes high the cycle after the pool count is below WM_MED, goes low the cycle after the count is at least WM_HIGH, and holds its value in between.
- R12: The erased pool returns block indices oldest first. `pool_cnt` gives the number of stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_sel | input | 1 | Fast-page pattern select (0 or 1) |
| req_valid | input | 1 | Write request present |
| req_hi | input | 1 | Request is high priority |
| req_gc | input | 1 | Request comes from garbage collection |
| fast_mode | input | 1 | Global fast mode |
| skip_budget | input | SKIP_W (16) | Largest allowed total of skipped pages |
| req_ready | output | 1 | Request can be accepted this cycle |
| resp_valid | output | 1 | Address response strobe |
| resp_blk | output | BLK_W (8) | Chosen block index |
| resp_page | output | PG_W (6) | Chosen page index |
| pool_push | input | 1 | Push an erased block index |
| pool_blk | input | BLK_W (8) | Block index being pushed |
| pool_cnt | output | CNT_W (5) | Erased-pool fill level |
| gc_req | output | 1 | Urgent garbage-collection request |
| bg_clean | output | 1 | Background cleaning request |
| skip_total | output | SKIP_W (16) | Pages skipped so far |
| blocks_used | output | SKIP_W (16) | Blocks opened so far |

## Verification
The bench keeps its own reference model of the write point, the pool and both hysteresis bands, and compares every response against it. It targets the following corner cases:
- A stalled request with an empty pool. A design that accepted it early would return a stale block.
- Budget exhaustion. A design that ignored the budget would keep skipping and overrun `skip_total`.
- The last page of a block under the every-other-page pattern, where no fast page remains. A design that ran past the end would return a wrapped page.
- Garbage-collection writes flagged high priority. A design that honoured the flag would skip pages that should be taken in order.

Pool levels are swept through the three water marks in both directions. This exposes a band that clears at the wrong mark or fails to hold its value in between.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  // R5 / R6: fast page classification by page index
  function automatic logic pg_fast(input logic [7:0] pg, input logic pat);
    if (pat) return ~pg[0];
    return (pg < 8'd4) || pg[1];
  endfunction
endpackage

// File: rtl/fwp_pool.sv
module fwp_pool #(
  parameter int DEPTH = 16,
  parameter int BLK_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [BLK_W-1:0] din,
  input  logic             pop,
  output logic [BLK_W-1:0] head,
  output logic [CW-1:0]    cnt
);
  logic [BLK_W-1:0] mem [DEPTH];
  logic [AW-1:0] rd, wr;
  logic do_push, do_pop;

  assign do_push = push && (cnt < CW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);
  assign head    = mem[rd];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd <= '0; wr <= '0; cnt <= '0;
    end else begin
      if (do_push) wr <= (wr == AW'(DEPTH - 1)) ? '0 : wr + AW'(1);
      if (do_pop)  rd <= (rd == AW'(DEPTH - 1)) ? '0 : rd + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R12
  pool_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  // R12
  pool_pop_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> cnt != '0);
endmodule

// File: rtl/fwp_wmark.sv
module fwp_wmark #(
  parameter int CW   = 5,
  parameter int LOW  = 2,
  parameter int MED  = 4,
  parameter int HIGH = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  output logic          gc_req,
  output logic          bg_clean
);
  logic below_low, below_med, at_med, at_high;
  assign below_low = cnt < CW'(LOW);
  assign below_med = cnt < CW'(MED);
  assign at_med    = !below_med;
  assign at_high   = cnt >= CW'(HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gc_req <= 1'b0; bg_clean <= 1'b0;
    end else begin
      if (below_low)   gc_req <= 1'b1;
      else if (at_med) gc_req <= 1'b0;
      if (below_med)    bg_clean <= 1'b1;
      else if (at_high) bg_clean <= 1'b0;
    end
  end

  // R10
  gc_set_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(gc_req) |-> $past(cnt) < CW'(LOW));
  // R10
  gc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(gc_req) |-> $past(cnt) >= CW'(MED));
  // R11
  bg_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(bg_clean) |-> $past(cnt) >= CW'(HIGH));
endmodule

// File: rtl/fwp_pager.sv
module fwp_pager
  import fwp_pkg::*;
#(
  parameter int PAGES  = 64,
  parameter int BLK_W  = 8,
  parameter int SKIP_W = 16,
  localparam int PG_W  = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pat,
  input  logic              take,
  input  logic              want_fast,
  input  logic [SKIP_W-1:0] budget,
  input  logic [BLK_W-1:0]  pool_head,
  output logic              open,
  output logic [BLK_W-1:0]  pick_blk,
  output logic [PG_W-1:0]   pick_pg,
  output logic [SKIP_W-1:0] skip_total,
  output logic [SKIP_W-1:0] blocks_used
);
  logic [BLK_W-1:0]  cur_blk;
  logic [PG_W-1:0]   wp, fpg;
  logic              fnd, skip_ok;
  logic [SKIP_W-1:0] gap, sk_add;

  // lowest fast page at or above the write point
  always_comb begin
    fnd = 1'b0;
    fpg = wp;
    for (int i = 0; i < PAGES; i++) begin
      if (!fnd && (i >= int'(wp)) && pg_fast(8'(i), pat)) begin
        fnd = 1'b1;
        fpg = PG_W'(i);
      end
    end
  end

  assign gap     = SKIP_W'(fpg) - SKIP_W'(wp);
  assign skip_ok = want_fast && fnd &&
                   (({1'b0, skip_total} + {1'b0, gap}) <= {1'b0, budget});
  assign pick_pg  = !open ? '0 : (skip_ok ? fpg : wp);
  assign pick_blk = open ? cur_blk : pool_head;
  assign sk_add   = (open && skip_ok) ? gap : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open <= 1'b0; cur_blk <= '0; wp <= '0;
      skip_total <= '0; blocks_used <= '0;
    end else if (take) begin
      if (!open) begin
        cur_blk     <= pool_head;
        blocks_used <= blocks_used + SKIP_W'(1);
      end
      wp         <= pick_pg + PG_W'(1);
      open       <= pick_pg != PG_W'(PAGES - 1);
      skip_total <= skip_total + sk_add;
    end
  end

  // R1
  pg_order_chk: assert property (@(posedge clk) disable iff (!rst_n) take && open |-> pick_pg >= wp);
  // R9
  skip_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (skip_total == $past(skip_total)) || (skip_total <= $past(budget)));
endmodule

// File: rtl/fwp_alloc.sv
module fwp_alloc #(
  parameter int PAGES      = 64,
  parameter int BLK_W      = 8,
  parameter int POOL_DEPTH = 16,
  parameter int SKIP_W     = 16,
  parameter int WM_LOW     = 2,
  parameter int WM_MED     = 4,
  parameter int WM_HIGH    = 6,
  localparam int PG_W  = $clog2(PAGES),
  localparam int CNT_W = $clog2(POOL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pat_sel,
  input  logic              req_valid,
  input  logic              req_hi,
  input  logic              req_gc,
  input  logic              fast_mode,
  input  logic [SKIP_W-1:0] skip_budget,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [BLK_W-1:0]  resp_blk,
  output logic [PG_W-1:0]   resp_page,
  input  logic              pool_push,
  input  logic [BLK_W-1:0]  pool_blk,
  output logic [CNT_W-1:0]  pool_cnt,
  output logic              gc_req,
  output logic              bg_clean,
  output logic [SKIP_W-1:0] skip_total,
  output logic [SKIP_W-1:0] blocks_used
);
  logic             wp_open, take, pop, want_fast;
  logic [BLK_W-1:0] head, pick_blk;
  logic [PG_W-1:0]  pick_pg;

  // R7 / R8: garbage-collection writes seek fast pages only in fast mode
  assign want_fast = fast_mode || (req_hi && !req_gc);
  assign req_ready = wp_open || (pool_cnt != '0);
  assign take      = req_valid && req_ready;
  assign pop       = take && !wp_open;

  fwp_pool #(.DEPTH(POOL_DEPTH), .BLK_W(BLK_W)) u_pool (
    .clk(clk), .rst_n(rst_n), .push(pool_push), .din(pool_blk),
    .pop(pop), .head(head), .cnt(pool_cnt));

  fwp_wmark #(.CW(CNT_W), .LOW(WM_LOW), .MED(WM_MED), .HIGH(WM_HIGH)) u_wm (
    .clk(clk), .rst_n(rst_n), .cnt(pool_cnt), .gc_req(gc_req), .bg_clean(bg_clean));

  fwp_pager #(.PAGES(PAGES), .BLK_W(BLK_W), .SKIP_W(SKIP_W)) u_pg (
    .clk(clk), .rst_n(rst_n), .pat(pat_sel), .take(take), .want_fast(want_fast),
    .budget(skip_budget), .pool_head(head), .open(wp_open), .pick_blk(pick_blk),
    .pick_pg(pick_pg), .skip_total(skip_total), .blocks_used(blocks_used));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0; resp_blk <= '0; resp_page <= '0;
    end else begin
      resp_valid <= take;
      if (take) begin
        resp_blk  <= pick_blk;
        resp_page <= pick_pg;
      end
    end
  end

  // R4
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n) !req_ready |-> pool_cnt == '0);
  // R2
  resp_chk: assert property (@(posedge clk) disable iff (!rst_n) take |=> resp_valid);
  // R2
  resp_one_chk: assert property (@(posedge clk) disable iff (!rst_n) !take |=> !resp_valid);
endmodule

// File: tb/sim_fwp_alloc.sv
module sim_fwp_alloc;
  localparam int PAGES = 64, DEPTH = 16, LOW = 2, MED = 4, HIGH = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pat_sel = 0, req_valid = 0, req_hi = 0, req_gc = 0, fast_mode = 0;
  logic [15:0] skip_budget = 16'd1000;
  logic req_ready, resp_valid;
  logic [7:0] resp_blk;
  logic [5:0] resp_page;
  logic pool_push = 0;
  logic [7:0] pool_blk = 0;
  logic [4:0] pool_cnt;
  logic gc_req, bg_clean;
  logic [15:0] skip_total, blocks_used;

  always #4 clk = ~clk;

  fwp_alloc u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference model
  int q[0:1023]; int qh = 0, qt = 0;
  bit m_open = 0; int m_blk = 0, m_wp = 0, m_skip = 0, m_used = 0;
  bit m_gc = 0, m_bg = 0;
  int prev_blk = -1, prev_pg = -1;
  int next_id = 20;

  function automatic bit ref_fast(int p, bit pat);
    if (pat) return (p % 2) == 0;
    return (p < 4) || ((p % 4) >= 2);
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wm_update();
    int c = qt - qh;
    if (c < LOW) m_gc = 1; else if (c >= MED) m_gc = 0;
    if (c < MED) m_bg = 1; else if (c >= HIGH) m_bg = 0;
  endtask

  task automatic chk_wm();
    chk(pool_cnt, qt - qh, "R12 count");
    chk(gc_req, m_gc, "R10");
    chk(bg_clean, m_bg, "R11");
  endtask

  task automatic push(int id);
    pool_push = 1; pool_blk = 8'(id);
    @(negedge clk);
    pool_push = 0;
    q[qt] = id; qt++;
    wm_update();
    @(negedge clk);
    wm_update();
    chk_wm();
  endtask

  // model the choice for one accepted write
  task automatic predict(bit hi, bit gc, bit fm, bit pat, int bud,
                         output int eb, output int ep, output string tag);
    bit wf = fm || (hi && !gc);
    tag = wf ? (pat ? "R6" : "R5") : (gc ? "R8" : "R7");
    if (!m_open) begin
      eb = q[qh]; qh++; ep = 0; m_used++; m_blk = eb; tag = "R3";
    end else begin
      int f = -1;
      eb = m_blk; ep = m_wp;
      if (wf) for (int p = m_wp; p < PAGES; p++) if (f < 0 && ref_fast(p, pat)) f = p;
      if (f >= 0 && (m_skip + (f - m_wp)) <= bud) begin
        m_skip += f - m_wp; ep = f;
        if (f != m_wp) tag = "R9";
      end
    end
    m_wp = ep + 1;
    m_open = (ep != PAGES - 1);
  endtask

  task automatic write(bit hi, bit gc, bit fm);
    int eb, ep; string tag;
    predict(hi, gc, fm, pat_sel, int'(skip_budget), eb, ep, tag);
    req_valid = 1; req_hi = hi; req_gc = gc; fast_mode = fm;
    do @(negedge clk); while (!resp_valid);
    req_valid = 0;
    chk(resp_blk, eb, {tag, " blk"});
    chk(resp_page, ep, {tag, " page"});
    if (eb == prev_blk) begin
      checks++;
      if (ep <= prev_pg) begin
        fails++;
        $display("FAIL R1 actual=%0d expected>%0d", ep, prev_pg);
      end
    end
    prev_blk = eb; prev_pg = ep;
    chk(skip_total, m_skip, "R9 skip_total");
    chk(blocks_used, m_used, "R3 blocks_used");
    @(negedge clk);
    chk(resp_valid, 0, "R2 single pulse");
    wm_update();
    chk_wm();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // reset state
    chk(req_ready, 0, "R4 reset ready");
    chk(resp_valid, 0, "R2 reset");
    chk(gc_req, 0, "R10 reset");
    chk(pool_cnt, 0, "R12 reset");
    rst_n = 1;
    @(negedge clk);
    wm_update();
    chk_wm();
    chk(skip_total, 0, "R9 reset");
    chk(blocks_used, 0, "R3 reset");

    // R4 stall with empty pool
    req_valid = 1; req_hi = 0; req_gc = 0; fast_mode = 0;
    repeat (5) @(negedge clk);
    chk(req_ready, 0, "R4 stall ready");
    chk(resp_valid, 0, "R4 no response");
    pool_push = 1; pool_blk = 8'd7;
    @(negedge clk);
    pool_push = 0;
    chk(req_ready, 1, "R4 ready after push");
    @(negedge clk);
    req_valid = 0;
    chk(resp_valid, 1, "R4 accepted");
    chk(resp_blk, 7, "R4 blk");
    chk(resp_page, 0, "R3 page0");
    m_open = 1; m_blk = 7; m_wp = 1; m_used = 1; prev_blk = 7; prev_pg = 0;
    @(negedge clk);
    wm_update(); chk_wm();

    // fill pool through the water marks
    for (int i = 0; i < 10; i++) begin push(next_id); next_id++; end

    // R5 directed: pattern 0 fast writes give 1,2,3,6,7,10
    pat_sel = 0;
    for (int i = 0; i < 6; i++) write(1, 0, 0);
    chk(resp_page, 10, "R5 directed");
    // R8: gc write with hi set takes next page
    write(1, 1, 0);
    chk(resp_page, 11, "R8 directed");

    // random phase: big then small budget, pattern changes
    for (int n = 0; n < 900; n++) begin
      if (n == 450) skip_budget = 16'(m_skip + 25);
      if ((n % 97) == 0) pat_sel = 1'($urandom);
      if ((qt - qh) < 3) begin
        for (int k = 0; k < 8; k++) begin push(next_id % 256); next_id++; end
      end
      write(1'($urandom), 1'($urandom), ($urandom % 5) == 0);
    end

    // R6 end of block: every other page, no fast page left at 63
    pat_sel = 1; skip_budget = 16'hFFFF;
    while (!(m_open && m_wp == 63)) write(0, 0, 0);
    write(1, 0, 0);
    chk(resp_page, 63, "R6 last page slow");

    // drain pool to watch marks fall
    while ((qt - qh) > 0) begin
      write(0, 0, 0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule